// File: doc/BRIEF.md
# Register-Offset Byte Store Unit

This block takes one 32-bit instruction word together with the register-file read data it needs. It recognises the word as a byte store whose address is a base register plus an index register. It picks the base (a general register or the stack pointer) and turns the index into a 64-bit offset by zero or sign extension. It adds the two modulo 2^64 and issues one registered byte-write request on a 64-bit data bus. The byte sits in the lane given by the low address bits, with a one-hot lane enable beside it.

Register number 31 has two meanings. In the base position it selects the stack pointer, which may be checked for 16-byte alignment. In the index and data positions it reads as zero. A word with the store's fixed bit pattern but a reserved extend option raises an undefined-instruction flag. A word that does not carry the pattern produces nothing, so other decoders can claim it. All results appear one clock after the valid strobe.

Top module: `bst_store_unit`

## Requirements
- R1: A word matches only when bits 31:21 equal 11'b00111000001 and bits 11:10 equal 2'b10; a non-matching valid word raises no request, no undefined flag and no fault.
- R2: For a matching word whose option field (bits 15:13) has bit 14 clear, `undef_flag` is raised and no request or fault is raised.
- R3: The offset comes from the index value by option: 3'b010 zero-extends its low 32 bits, 3'b110 sign-extends its low 32 bits, 3'b011 and 3'b111 use all 64 bits as they are.
- R4: Bit 12 of the word has no effect on the address or on any other output.
- R5: When bits 9:5 equal 31 the base is `sp_value`; otherwise it is `base_rdata`.
- R6: When bits 20:16 equal 31 the offset is zero, and when bits 4:0 equal 31 the stored byte is zero, whatever the read data.
- R7: `st_addr` is base plus offset modulo 2^64.
- R8: With base 31, `sp_chk_en` high and any of `sp_value[3:0]` set, `align_fault` is raised instead of a request; a general-register base or a low `sp_chk_en` never faults.
- R9: On a request `st_lane_en` has exactly bit `st_addr[2:0]` set, and `st_wdata` holds the low byte of the transfer value in bits 8k+7:8k for that lane k and zeros elsewhere.
- R10: `st_priv` on a request is 1 exactly when `cur_el` was nonzero.
- R11: Flags are registered: they reflect the input presented one clock earlier, and a cycle with `insn_valid` low yields all three flags low on the next clock.
- R12: While `rst_n` is low, `st_req`, `undef_flag` and `align_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word |
| base_rdata | input | 64 | Read data of the base general register |
| index_rdata | input | 64 | Read data of the index register |
| xfer_rdata | input | 64 | Read data of the transfer register |
| sp_value | input | 64 | Current stack pointer |
| sp_chk_en | input | 1 | Enables the stack pointer alignment check |
| cur_el | input | 2 | Current exception level, 0 is unprivileged |
| st_req | output | 1 | Byte store request, one cycle |
| st_addr | output | 64 | Effective byte address |
| st_wdata | output | 64 | Write data with the byte in its lane |
| st_lane_en | output | 8 | One-hot byte-lane enable |
| st_priv | output | 1 | Request made at a privileged level |
| undef_flag | output | 1 | Undefined instruction, one cycle |
| align_fault | output | 1 | Stack pointer alignment fault, one cycle |

## Verification
The block holds no state beyond its output registers, so a wrong decode, a wrong extension or a wrong register-31 choice shows at the ports one clock after the valid strobe. It appears as a wrong address or byte, a lane enable that disagrees with the address, or the wrong flag of the three. The scoreboard compares every cycle against a model built from the requirements. It uses index values whose upper half and bit 31 differ, so each extension mode gives a distinct address. The stack pointer values differ from the base register data, and carries cross bit 63. A flag that sticks or fires on an idle cycle is caught on the very next clock.

// File: rtl/bst_pkg.sv
package bst_pkg;

   localparam int unsigned INSN_W    = 32;
   localparam int unsigned RIDX_W    = 5;
   localparam logic [RIDX_W-1:0] ZERO_RIDX = 5'd31;

   // fixed opcode bits 31:21 and 11:10
   localparam logic [10:0] OPC_HI = 11'b001_1100_0001;
   localparam logic [1:0]  OPC_LO = 2'b10;

   typedef enum logic [1:0] {
      EXT_ZERO32 = 2'd0,
      EXT_SIGN32 = 2'd1,
      EXT_WHOLE  = 2'd2
   } bst_ext_e;

   typedef struct packed {
      logic                hit;
      logic                undef;
      bst_ext_e            ext;
      logic [RIDX_W-1:0]   rm;
      logic [RIDX_W-1:0]   rn;
      logic [RIDX_W-1:0]   rt;
   } bst_dec_t;

endpackage

// File: rtl/bst_decode.sv
module bst_decode
   import bst_pkg::*;
(
   input  logic [INSN_W-1:0] insn_i,
   output bst_dec_t          dec_o
);

   logic [2:0] opt;
   logic       unused_scale;

   assign opt          = insn_i[15:13];
   assign unused_scale = insn_i[12];

   always_comb begin
      dec_o.hit   = (insn_i[31:21] == OPC_HI) && (insn_i[11:10] == OPC_LO);
      dec_o.undef = dec_o.hit && !opt[1];
      if (opt[0])
         dec_o.ext = EXT_WHOLE;
      else if (opt[2])
         dec_o.ext = EXT_SIGN32;
      else
         dec_o.ext = EXT_ZERO32;
      dec_o.rm = insn_i[20:16];
      dec_o.rn = insn_i[9:5];
      dec_o.rt = insn_i[4:0];
   end

endmodule

// File: rtl/bst_index_ext.sv
module bst_index_ext
   import bst_pkg::*;
#(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic [XLEN-1:0] raw_i,
   input  bst_ext_e        kind_i,
   output logic [XLEN-1:0] offset_o
);

   if (NARROW_W > XLEN || NARROW_W == 0) begin : g_bad_narrow
      $error("bst_index_ext: NARROW_W must be 1..XLEN");
   end

   if (XLEN > NARROW_W) begin : g_extend
      localparam int unsigned PAD_W = XLEN - NARROW_W;
      logic [NARROW_W-1:0] low;
      assign low = raw_i[NARROW_W-1:0];
      always_comb begin
         case (kind_i)
            EXT_ZERO32: offset_o = {{PAD_W{1'b0}}, low};
            EXT_SIGN32: offset_o = {{PAD_W{low[NARROW_W-1]}}, low};
            default:    offset_o = raw_i;
         endcase
      end
   end else begin : g_same
      bst_ext_e unused_kind;
      assign unused_kind = kind_i;
      assign offset_o    = raw_i;
   end

endmodule

// File: rtl/bst_lane_steer.sv
module bst_lane_steer #(
   parameter int unsigned BUS_BYTES = 8,
   localparam int unsigned LANE_W   = $clog2(BUS_BYTES),
   localparam int unsigned BUS_W    = 8 * BUS_BYTES
) (
   input  logic [LANE_W-1:0]    lane_sel_i,
   input  logic [7:0]           byte_i,
   output logic [BUS_BYTES-1:0] lane_en_o,
   output logic [BUS_W-1:0]     wdata_o
);

   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      assign lane_en_o[k]       = (lane_sel_i == LANE_W'(k));
      assign wdata_o[8*k +: 8]  = lane_en_o[k] ? byte_i : 8'h00;
   end

endmodule

// File: rtl/bst_store_unit.sv
module bst_store_unit
   import bst_pkg::*;
#(
   parameter int unsigned XLEN          = 64,
   parameter int unsigned NARROW_W      = 32,
   parameter int unsigned BUS_BYTES     = 8,
   parameter int unsigned SP_ALIGN_LOG2 = 4,
   parameter int unsigned EL_W          = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   insn_valid,
   input  logic [INSN_W-1:0]      insn_word,
   input  logic [XLEN-1:0]        base_rdata,
   input  logic [XLEN-1:0]        index_rdata,
   input  logic [XLEN-1:0]        xfer_rdata,
   input  logic [XLEN-1:0]        sp_value,
   input  logic                   sp_chk_en,
   input  logic [EL_W-1:0]        cur_el,
   output logic                   st_req,
   output logic [XLEN-1:0]        st_addr,
   output logic [8*BUS_BYTES-1:0] st_wdata,
   output logic [BUS_BYTES-1:0]   st_lane_en,
   output logic                   st_priv,
   output logic                   undef_flag,
   output logic                   align_fault
);

   localparam int unsigned LANE_W = $clog2(BUS_BYTES);
   localparam int unsigned BUS_W  = 8 * BUS_BYTES;

   if (BUS_BYTES < 2 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
      $error("bst_store_unit: BUS_BYTES must be a power of two >= 2");
   end
   if (XLEN < 8 || LANE_W > XLEN) begin : g_bad_xlen
      $error("bst_store_unit: XLEN too small");
   end
   if (SP_ALIGN_LOG2 >= XLEN) begin : g_bad_align
      $error("bst_store_unit: SP_ALIGN_LOG2 must be below XLEN");
   end
   if (EL_W == 0) begin : g_bad_el
      $error("bst_store_unit: EL_W must be nonzero");
   end

   bst_dec_t            dec;
   logic [XLEN-1:0]     index_val;
   logic [XLEN-1:0]     offset;
   logic [XLEN-1:0]     base_val;
   logic [XLEN-1:0]     addr_nx;
   logic [7:0]          byte_val;
   logic [BUS_BYTES-1:0] lane_nx;
   logic [BUS_W-1:0]    wdata_nx;
   logic                use_sp;
   logic                sp_misaligned;
   logic                undef_nx;
   logic                fault_nx;
   logic                issue_nx;
   logic                priv_nx;
   logic [XLEN-9:0]     unused_xfer_hi;

   assign unused_xfer_hi = xfer_rdata[XLEN-1:8];

   bst_decode u_decode (
      .insn_i (insn_word),
      .dec_o  (dec)
   );

   // register 31 reads as zero for index and data, as stack pointer for base
   assign index_val = (dec.rm == ZERO_RIDX) ? '0 : index_rdata;
   assign byte_val  = (dec.rt == ZERO_RIDX) ? 8'h00 : xfer_rdata[7:0];
   assign use_sp    = (dec.rn == ZERO_RIDX);
   assign base_val  = use_sp ? sp_value : base_rdata;

   bst_index_ext #(
      .XLEN     (XLEN),
      .NARROW_W (NARROW_W)
   ) u_index_ext (
      .raw_i    (index_val),
      .kind_i   (dec.ext),
      .offset_o (offset)
   );

   assign addr_nx = base_val + offset;

   bst_lane_steer #(
      .BUS_BYTES (BUS_BYTES)
   ) u_lane_steer (
      .lane_sel_i (addr_nx[LANE_W-1:0]),
      .byte_i     (byte_val),
      .lane_en_o  (lane_nx),
      .wdata_o    (wdata_nx)
   );

   if (SP_ALIGN_LOG2 == 0) begin : g_no_align
      assign sp_misaligned = 1'b0;
   end else begin : g_align
      assign sp_misaligned = |sp_value[SP_ALIGN_LOG2-1:0];
   end

   assign undef_nx = insn_valid && dec.hit && dec.undef;
   assign fault_nx = insn_valid && dec.hit && !dec.undef
                     && use_sp && sp_chk_en && sp_misaligned;
   assign issue_nx = insn_valid && dec.hit && !dec.undef && !fault_nx;
   assign priv_nx  = (cur_el != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_req      <= 1'b0;
         undef_flag  <= 1'b0;
         align_fault <= 1'b0;
      end else begin
         st_req      <= issue_nx;
         undef_flag  <= undef_nx;
         align_fault <= fault_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_addr    <= '0;
         st_wdata   <= '0;
         st_lane_en <= '0;
         st_priv    <= 1'b0;
      end else if (issue_nx) begin
         st_addr    <= addr_nx;
         st_wdata   <= wdata_nx;
         st_lane_en <= lane_nx;
         st_priv    <= priv_nx;
      end
   end

endmodule

// File: rtl/bst_store_chk.sv
module bst_store_chk #(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned BUS_BYTES = 8,
   parameter int unsigned EL_W      = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   insn_valid,
   input logic [EL_W-1:0]        cur_el,
   input logic                   st_req,
   input logic [XLEN-1:0]        st_addr,
   input logic [8*BUS_BYTES-1:0] st_wdata,
   input logic [BUS_BYTES-1:0]   st_lane_en,
   input logic                   st_priv,
   input logic                   undef_flag,
   input logic                   align_fault
);

   localparam int unsigned LANE_W = $clog2(BUS_BYTES);

   logic [8*BUS_BYTES-1:0] lane_mask;
   logic [XLEN-1:0]        unused_addr;

   assign unused_addr = st_addr;

   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_mask
      assign lane_mask[8*k +: 8] = {8{st_lane_en[k]}};
   end

   // R2 R8
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_req, undef_flag, align_fault}));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(insn_valid) |-> !(st_req || undef_flag || align_fault));

   // R9
   lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_req |-> ($countones(st_lane_en) == 1));

   // R9
   lane_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_req |-> st_lane_en[st_addr[LANE_W-1:0]]);

   // R9
   lane_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_req |-> ((st_wdata & ~lane_mask) == '0));

   // R10
   priv_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_req |-> (st_priv == ($past(cur_el) != '0)));

endmodule

bind bst_store_unit bst_store_chk #(
   .XLEN      (XLEN),
   .BUS_BYTES (BUS_BYTES),
   .EL_W      (EL_W)
) u_store_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .insn_valid  (insn_valid),
   .cur_el      (cur_el),
   .st_req      (st_req),
   .st_addr     (st_addr),
   .st_wdata    (st_wdata),
   .st_lane_en  (st_lane_en),
   .st_priv     (st_priv),
   .undef_flag  (undef_flag),
   .align_fault (align_fault)
);

// File: tb/test_bst_store_unit.sv
module test_bst_store_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [31:0] insn_word = '0;
   logic [63:0] base_rdata = '0, index_rdata = '0, xfer_rdata = '0, sp_value = '0;
   logic        sp_chk_en = 1'b0;
   logic [1:0]  cur_el = '0;
   logic        st_req, st_priv, undef_flag, align_fault;
   logic [63:0] st_addr, st_wdata;
   logic [7:0]  st_lane_en;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   bst_store_unit i_bst_store_unit (
      .clk, .rst_n, .insn_valid, .insn_word, .base_rdata, .index_rdata,
      .xfer_rdata, .sp_value, .sp_chk_en, .cur_el, .st_req, .st_addr,
      .st_wdata, .st_lane_en, .st_priv, .undef_flag, .align_fault
   );

   typedef struct {
      logic        req, undef, fault, priv;
      logic [63:0] addr, wdata;
      logic [7:0]  lane;
      string       tag;
   } exp_t;

   exp_t exp_q[$];

   function automatic logic [31:0] enc(input logic [4:0] rm, input logic [2:0] opt,
                                       input logic s, input logic [4:0] rn,
                                       input logic [4:0] rt);
      return {11'b00111000001, rm, opt, s, 2'b10, rn, rt};
   endfunction

   function automatic exp_t model(input logic v, input logic [31:0] w,
                                  input logic [63:0] b, i, x, s,
                                  input logic chk, input logic [1:0] el,
                                  input string tag);
      exp_t e;
      logic [63:0] idx, off, base;
      logic [7:0]  dat;
      e.req = 0; e.undef = 0; e.fault = 0; e.priv = 0;
      e.addr = '0; e.wdata = '0; e.lane = '0; e.tag = tag;
      if (v && w[31:21] == 11'b00111000001 && w[11:10] == 2'b10) begin
         if (!w[14]) e.undef = 1;
         else if (w[9:5] == 5'd31 && chk && s[3:0] != 4'h0) e.fault = 1;
         else begin
            idx = (w[20:16] == 5'd31) ? 64'd0 : i;
            case (w[15:13])
               3'b010:  off = {32'd0, idx[31:0]};
               3'b110:  off = {{32{idx[31]}}, idx[31:0]};
               default: off = idx;
            endcase
            base = (w[9:5] == 5'd31) ? s : b;
            dat = (w[4:0] == 5'd31) ? 8'h00 : x[7:0];
            e.req = 1;
            e.addr = base + off;
            e.lane = 8'b1 << e.addr[2:0];
            e.wdata = {56'd0, dat} << (8 * e.addr[2:0]);
            e.priv = (el != 2'd0);
         end
      end
      return e;
   endfunction

   task automatic drive(input logic v, input logic [31:0] w,
                        input logic [63:0] b, i, x, s,
                        input logic chk, input logic [1:0] el, input string tag);
      @(negedge clk);
      insn_valid = v; insn_word = w; base_rdata = b; index_rdata = i;
      xfer_rdata = x; sp_value = s; sp_chk_en = chk; cur_el = el;
      exp_q.push_back(model(v, w, b, i, x, s, chk, el, tag));
   endtask

   task automatic idle(input string tag);
      drive(1'b0, enc(5'd1, 3'b011, 1'b0, 5'd2, 5'd3), 64'h100, 64'h8,
            64'hAB, 64'h0, 1'b0, 2'd1, tag);
   endtask

   // monitor: pop at the edge that registers the item, compare at the next falling edge
   initial begin : monitor
      exp_t c;
      forever begin
         @(posedge clk);
         if (exp_q.size() > 0) begin
            c = exp_q.pop_front();
            @(negedge clk);
            n_run++;
            if (st_req !== c.req || undef_flag !== c.undef || align_fault !== c.fault ||
                (c.req && (st_addr !== c.addr || st_wdata !== c.wdata ||
                           st_lane_en !== c.lane || st_priv !== c.priv))) begin
               n_fail++;
               $display("FAIL %s: got req=%b und=%b flt=%b addr=%h data=%h lane=%b priv=%b exp req=%b und=%b flt=%b addr=%h data=%h lane=%b priv=%b",
                        c.tag, st_req, undef_flag, align_fault, st_addr, st_wdata,
                        st_lane_en, st_priv, c.req, c.undef, c.fault, c.addr,
                        c.wdata, c.lane, c.priv);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got hung run, exp completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R12: flags low in reset
      n_run++;
      if (st_req !== 1'b0 || undef_flag !== 1'b0 || align_fault !== 1'b0) begin
         n_fail++;
         $display("FAIL R12 reset: got %b%b%b exp 000", st_req, undef_flag, align_fault);
      end
      rst_n = 1'b1;
      idle("R11 idle after reset");

      // R3 extension modes, R7 address sum
      drive(1, enc(5'd4, 3'b010, 0, 5'd5, 5'd6), 64'h1000, 64'hFFFF_FFFF_8000_0010,
            64'h5A, 64'h0, 0, 2'd1, "R3 zero-extend low word");
      drive(1, enc(5'd4, 3'b110, 0, 5'd5, 5'd6), 64'h2000, 64'h0000_0000_FFFF_FFF0,
            64'h5B, 64'h0, 0, 2'd1, "R3 sign-extend low word");
      drive(1, enc(5'd4, 3'b111, 0, 5'd5, 5'd6), 64'h2000, 64'h1234_0000_8000_0003,
            64'h5C, 64'h0, 0, 2'd1, "R3 whole index sxtx");
      drive(1, enc(5'd4, 3'b011, 0, 5'd5, 5'd6), 64'h2000, 64'h1234_0000_8000_0003,
            64'h5D, 64'h0, 0, 2'd1, "R3 whole index lsl");
      // R4 scale bit ignored
      drive(1, enc(5'd4, 3'b011, 1, 5'd5, 5'd6), 64'h2000, 64'h1234_0000_8000_0003,
            64'h5D, 64'h0, 0, 2'd1, "R4 scale bit set lsl");
      drive(1, enc(5'd4, 3'b110, 1, 5'd5, 5'd6), 64'h2000, 64'h0000_0000_FFFF_FFF0,
            64'h5B, 64'h0, 0, 2'd1, "R4 scale bit set sxtw");

      // R2 reserved options
      for (int k = 0; k < 8; k++) begin
         if (k[1] == 1'b0)
            drive(1, enc(5'd4, 3'(k), 0, 5'd31, 5'd6), 64'h10, 64'h8, 64'h11,
                  64'h3, 1, 2'd0, "R2 reserved option");
      end

      // R1 non-matching words
      drive(1, enc(5'd4, 3'b011, 0, 5'd5, 5'd6) | 32'h0040_0000, 64'h10, 64'h8,
            64'h11, 64'h0, 0, 2'd1, "R1 opc bit22 set");
      drive(1, enc(5'd4, 3'b011, 0, 5'd5, 5'd6) ^ 32'h0000_0C00, 64'h10, 64'h8,
            64'h11, 64'h0, 0, 2'd1, "R1 bits11:10 wrong");
      drive(1, enc(5'd4, 3'b000, 0, 5'd5, 5'd6) & ~32'h0020_0000, 64'h10, 64'h8,
            64'h11, 64'h0, 0, 2'd1, "R1 bit21 clear no undef");
      drive(1, enc(5'd4, 3'b011, 0, 5'd5, 5'd6) | 32'h4000_0000, 64'h10, 64'h8,
            64'h11, 64'h0, 0, 2'd1, "R1 size bits wrong");

      // R5 base choice, R8 alignment
      drive(1, enc(5'd4, 3'b011, 0, 5'd31, 5'd6), 64'hDEAD_0000, 64'h5,
            64'h77, 64'h0000_8000_0000_0100, 1, 2'd1, "R5 sp base aligned");
      drive(1, enc(5'd4, 3'b011, 0, 5'd31, 5'd6), 64'hDEAD_0000, 64'h5,
            64'h77, 64'h0000_8000_0000_0108, 1, 2'd1, "R8 sp misaligned faults");
      drive(1, enc(5'd4, 3'b011, 0, 5'd31, 5'd6), 64'hDEAD_0000, 64'h5,
            64'h77, 64'h0000_8000_0000_0108, 0, 2'd1, "R8 check disabled stores");
      drive(1, enc(5'd4, 3'b011, 0, 5'd7, 5'd6), 64'h0000_0000_0000_0109, 64'h5,
            64'h77, 64'h0000_8000_0000_0108, 1, 2'd1, "R8 general base never faults");
      drive(1, enc(5'd4, 3'b000, 0, 5'd31, 5'd6), 64'h10, 64'h5,
            64'h77, 64'h1, 1, 2'd1, "R2 undef wins over misalign");

      // R6 zero register
      drive(1, enc(5'd31, 3'b011, 0, 5'd5, 5'd6), 64'h3000, 64'hFFFF_0000_1234_5678,
            64'hC3, 64'h0, 0, 2'd1, "R6 index reg 31 zero");
      drive(1, enc(5'd4, 3'b011, 0, 5'd5, 5'd31), 64'h3000, 64'h4,
            64'hC3, 64'h0, 0, 2'd1, "R6 data reg 31 zero");

      // R7 wrap
      drive(1, enc(5'd4, 3'b111, 0, 5'd5, 5'd6), 64'hFFFF_FFFF_FFFF_FFF0, 64'h25,
            64'h9E, 64'h0, 0, 2'd1, "R7 address wraps");
      drive(1, enc(5'd4, 3'b110, 0, 5'd5, 5'd6), 64'h0000_0000_0000_0004, 64'h8000_0000,
            64'h9F, 64'h0, 0, 2'd1, "R7 negative offset wraps");

      // R9 lane sweep
      for (int k = 0; k < 8; k++)
         drive(1, enc(5'd4, 3'b010, 0, 5'd5, 5'd6), 64'h4000, 64'(k),
               64'h100 + 64'(k), 64'h0, 0, 2'd1, "R9 lane sweep");

      // R10 privilege
      for (int k = 0; k < 4; k++)
         drive(1, enc(5'd4, 3'b011, 0, 5'd5, 5'd6), 64'h5000, 64'h1,
               64'h42, 64'h0, 0, 2'(k), "R10 privilege by level");

      // R11 valid low on a matching word
      drive(0, enc(5'd4, 3'b011, 0, 5'd5, 5'd6), 64'h5000, 64'h1,
            64'h42, 64'h0, 0, 2'd1, "R11 valid low no request");
      drive(0, enc(5'd4, 3'b000, 0, 5'd5, 5'd6), 64'h5000, 64'h1,
            64'h42, 64'h0, 0, 2'd1, "R11 valid low no undef");
      idle("R11 trailing idle");
      idle("R11 trailing idle");

      repeat (3) @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule